// File: doc/BRIEF.md
# Asynchronous Memory Read Sequencer

This block turns one read request into the pin activity needed to fetch words from an external asynchronous memory in normal mode. A request carries a start address, a beat count and a chip-select index. The block waits out the turnaround count programmed for that chip select. It then checks once more that the request still holds priority. After that it runs one access per beat. Each access has a setup phase, a strobe phase and a hold phase. Every word read is returned on a one-cycle valid strobe.

Each chip select has its own programmable turnaround, setup, strobe and hold counts and its own mode bit. The block remembers the last read it completed. A new read to that same chip select starts its setup phase without a turnaround gap. A request that loses priority by the end of turnaround is dropped before it touches the bus, and it is reported by its own pulse.

Top module: `async_rd_seq`

## Requirements
- R1: After synchronous reset, every chip select, output enable and byte enable is high (inactive), `req_ready` is 1, and `rd_valid`, `done_pulse` and `abort_pulse` are 0.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. If the last completed read went to another chip select, or no read has completed, the request's chip select first goes low TA cycles after the acceptance edge, where TA is that chip select's turnaround count.
- R3: If the last completed read went to the same chip select, no turnaround is inserted and the chip select goes low in the first cycle after acceptance.
- R4: The grant is sampled once, on the final turnaround edge, or on the acceptance edge when no turnaround applies. If it is 0 there, `abort_pulse` is high for one cycle in the cycle right after that edge, and no chip select is asserted. If it is 1 there, the access proceeds, whatever the grant was earlier.
- R5: An aborted request clears the record of the last completed read, so the next request pays the full turnaround.
- R6: Each access keeps its chip select low for setup+1, then strobe+1, then hold+1 cycles. Output enable is low only during the strobe+1 cycles.
- R7: Read data is captured on the last strobe cycle. It appears on `rd_data` with `rd_valid` high for one cycle, in the first hold cycle.
- R8: `req_len` holds the beat count minus one. Beats run back to back with no turnaround between them, and the address rises by one per beat, wrapping at the top of the address range.
- R9: `done_pulse` is high for one cycle in the cycle after the last hold cycle of the last beat. `req_ready` is 1 from that cycle on.
- R10: The write enable stays high at all times.
- R11: While a chip select is low, the byte enables are all 0 when that chip select's mode bit is 0 (normal mode) and all 1 when it is 1. Outside an access they are all 1.
- R12: Only the chip select named by the request is asserted, and the timing counts and mode bit used are the ones programmed for that chip select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request present |
| req_addr | input | ADDR_W | Word address of first beat |
| req_len | input | LEN_W | Beat count minus one |
| req_cs | input | CS_W | Target chip-select index |
| req_grant | input | 1 | Request still has highest priority |
| req_ready | output | 1 | Sequencer idle and able to accept |
| cfg_turn | input | NUM_CS*CNT_W | Turnaround cycles per chip select |
| cfg_setup | input | NUM_CS*CNT_W | Setup count per chip select |
| cfg_strobe | input | NUM_CS*CNT_W | Strobe count per chip select |
| cfg_hold | input | NUM_CS*CNT_W | Hold count per chip select |
| cfg_mode | input | NUM_CS | Mode bit per chip select, 0 = normal |
| mem_cs_n | output | NUM_CS | Active-low chip selects |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_be_n | output | BE_W | Active-low byte enables |
| mem_addr | output | ADDR_W | Memory address |
| mem_din | input | DATA_W | Data returned by memory |
| rd_data | output | DATA_W | Captured read word |
| rd_valid | output | 1 | `rd_data` valid strobe |
| done_pulse | output | 1 | Request completed |
| abort_pulse | output | 1 | Request dropped after losing priority |

## Verification
A phase counter that reloads with the wrong value shifts the chip-select and output-enable edges by whole cycles. That shows at the pins within the same access. A last-read record that is wrong shows only on the next request, which starts TA cycles too early or too late, before its first chip-select edge. A beat counter that is off by one shows as an extra or missing access and as a done pulse moved by a whole access length. A mis-decoded chip-select index asserts the wrong pin on the first access cycle.

// File: rtl/ars_pkg.sv
package ars_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_TURN,
        PH_SETUP,
        PH_STROBE,
        PH_HOLD
    } phase_e;

    typedef struct packed {
        logic bus;   // chip select held active
        logic oe;    // output enable active
    } pin_ctl_t;

    function automatic pin_ctl_t phase_pins(phase_e p);
        pin_ctl_t c;
        c.bus = (p == PH_SETUP) || (p == PH_STROBE) || (p == PH_HOLD);
        c.oe  = (p == PH_STROBE);
        return c;
    endfunction

endpackage

// File: rtl/ars_cfg_sel.sv
module ars_cfg_sel #(
    parameter int NUM_CS = 4,
    parameter int CNT_W  = 4,
    parameter int CS_W   = 2
) (
    input  logic [NUM_CS*CNT_W-1:0] turn_f,
    input  logic [NUM_CS*CNT_W-1:0] setup_f,
    input  logic [NUM_CS*CNT_W-1:0] strobe_f,
    input  logic [NUM_CS*CNT_W-1:0] hold_f,
    input  logic [NUM_CS-1:0]       mode_f,
    input  logic [CS_W-1:0]         sel,
    output logic [CNT_W-1:0]        turn,
    output logic [CNT_W-1:0]        setup,
    output logic [CNT_W-1:0]        strobe,
    output logic [CNT_W-1:0]        hold,
    output logic                    mode
);
    logic [CNT_W-1:0] turn_a   [NUM_CS];
    logic [CNT_W-1:0] setup_a  [NUM_CS];
    logic [CNT_W-1:0] strobe_a [NUM_CS];
    logic [CNT_W-1:0] hold_a   [NUM_CS];

    for (genvar g = 0; g < NUM_CS; g++) begin : g_unpack
        assign turn_a[g]   = turn_f[g*CNT_W +: CNT_W];
        assign setup_a[g]  = setup_f[g*CNT_W +: CNT_W];
        assign strobe_a[g] = strobe_f[g*CNT_W +: CNT_W];
        assign hold_a[g]   = hold_f[g*CNT_W +: CNT_W];
    end

    assign turn   = turn_a[sel];
    assign setup  = setup_a[sel];
    assign strobe = strobe_a[sel];
    assign hold   = hold_a[sel];
    assign mode   = mode_f[sel];
endmodule

// File: rtl/ars_phase_ctrl.sv
module ars_phase_ctrl
    import ars_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 3,
    parameter int CNT_W  = 4,
    parameter int CS_W   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [CS_W-1:0]   req_cs,
    input  logic              req_grant,
    input  logic [CNT_W-1:0]  t_turn,
    input  logic [CNT_W-1:0]  t_setup,
    input  logic [CNT_W-1:0]  t_strobe,
    input  logic [CNT_W-1:0]  t_hold,
    output phase_e            phase,
    output logic [CS_W-1:0]   cur_cs,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              strobe_last,
    output logic              done_pulse,
    output logic              abort_pulse
);
    logic [CNT_W-1:0] cnt;
    logic [LEN_W-1:0] beats_left;
    logic             hist_valid;
    logic [CS_W-1:0]  hist_cs;
    logic             skip_turn;

    assign skip_turn   = hist_valid && (hist_cs == req_cs);
    assign strobe_last = (phase == PH_STROBE) && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase       <= PH_IDLE;
            cnt         <= '0;
            beats_left  <= '0;
            cur_cs      <= '0;
            cur_addr    <= '0;
            hist_valid  <= 1'b0;
            hist_cs     <= '0;
            done_pulse  <= 1'b0;
            abort_pulse <= 1'b0;
        end else begin
            done_pulse  <= 1'b0;
            abort_pulse <= 1'b0;
            unique case (phase)
                PH_IDLE: begin
                    if (req_valid) begin
                        cur_cs     <= req_cs;
                        cur_addr   <= req_addr;
                        beats_left <= req_len;
                        if (skip_turn || (t_turn == '0)) begin
                            if (req_grant) begin
                                phase <= PH_SETUP;
                                cnt   <= t_setup;
                            end else begin
                                abort_pulse <= 1'b1;
                                hist_valid  <= 1'b0;
                            end
                        end else begin
                            phase <= PH_TURN;
                            cnt   <= t_turn - 1'b1;
                        end
                    end
                end
                PH_TURN: begin
                    if (cnt != '0) begin
                        cnt <= cnt - 1'b1;
                    end else if (req_grant) begin
                        phase <= PH_SETUP;
                        cnt   <= t_setup;
                    end else begin
                        phase       <= PH_IDLE;
                        abort_pulse <= 1'b1;
                        hist_valid  <= 1'b0;
                    end
                end
                PH_SETUP: begin
                    if (cnt != '0) begin
                        cnt <= cnt - 1'b1;
                    end else begin
                        phase <= PH_STROBE;
                        cnt   <= t_strobe;
                    end
                end
                PH_STROBE: begin
                    if (cnt != '0) begin
                        cnt <= cnt - 1'b1;
                    end else begin
                        phase <= PH_HOLD;
                        cnt   <= t_hold;
                    end
                end
                PH_HOLD: begin
                    if (cnt != '0) begin
                        cnt <= cnt - 1'b1;
                    end else if (beats_left == '0) begin
                        phase      <= PH_IDLE;
                        done_pulse <= 1'b1;
                        hist_valid <= 1'b1;
                        hist_cs    <= cur_cs;
                    end else begin
                        phase      <= PH_SETUP;
                        cnt        <= t_setup;
                        beats_left <= beats_left - 1'b1;
                        cur_addr   <= cur_addr + 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ars_pin_drv.sv
module ars_pin_drv
    import ars_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int CS_W   = 2,
    parameter int BE_W   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  phase_e            phase,
    input  logic [CS_W-1:0]   cur_cs,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic              cs_mode,
    input  logic              strobe_last,
    input  logic [DATA_W-1:0] mem_din,
    output logic [NUM_CS-1:0] mem_cs_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [BE_W-1:0]   mem_be_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    pin_ctl_t ctl;

    assign ctl = phase_pins(phase);

    for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
        assign mem_cs_n[g] = ~(ctl.bus && (cur_cs == CS_W'(g)));
    end

    assign mem_oe_n = ~ctl.oe;
    assign mem_we_n = 1'b1;
    assign mem_be_n = (ctl.bus && !cs_mode) ? '0 : '1;
    assign mem_addr = cur_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= strobe_last;
            if (strobe_last) rd_data <= mem_din;
        end
    end
endmodule

// File: rtl/async_rd_seq.sv
module async_rd_seq
    import ars_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int LEN_W  = 3,
    parameter int CNT_W  = 4,
    localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
    localparam int BE_W  = DATA_W / 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    req_valid,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [LEN_W-1:0]        req_len,
    input  logic [CS_W-1:0]         req_cs,
    input  logic                    req_grant,
    output logic                    req_ready,
    input  logic [NUM_CS*CNT_W-1:0] cfg_turn,
    input  logic [NUM_CS*CNT_W-1:0] cfg_setup,
    input  logic [NUM_CS*CNT_W-1:0] cfg_strobe,
    input  logic [NUM_CS*CNT_W-1:0] cfg_hold,
    input  logic [NUM_CS-1:0]       cfg_mode,
    output logic [NUM_CS-1:0]       mem_cs_n,
    output logic                    mem_oe_n,
    output logic                    mem_we_n,
    output logic [BE_W-1:0]         mem_be_n,
    output logic [ADDR_W-1:0]       mem_addr,
    input  logic [DATA_W-1:0]       mem_din,
    output logic [DATA_W-1:0]       rd_data,
    output logic                    rd_valid,
    output logic                    done_pulse,
    output logic                    abort_pulse
);
    phase_e            phase;
    logic [CS_W-1:0]   cur_cs;
    logic [CS_W-1:0]   sel_cs;
    logic [ADDR_W-1:0] cur_addr;
    logic [CNT_W-1:0]  t_turn, t_setup, t_strobe, t_hold;
    logic              t_mode;
    logic              strobe_last;

    assign req_ready = (phase == PH_IDLE);
    assign sel_cs    = (phase == PH_IDLE) ? req_cs : cur_cs;

    ars_cfg_sel #(.NUM_CS(NUM_CS), .CNT_W(CNT_W), .CS_W(CS_W)) cfg_i (
        .turn_f(cfg_turn), .setup_f(cfg_setup), .strobe_f(cfg_strobe),
        .hold_f(cfg_hold), .mode_f(cfg_mode), .sel(sel_cs),
        .turn(t_turn), .setup(t_setup), .strobe(t_strobe),
        .hold(t_hold), .mode(t_mode)
    );

    ars_phase_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .CNT_W(CNT_W), .CS_W(CS_W)) ctrl_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_len(req_len), .req_cs(req_cs), .req_grant(req_grant),
        .t_turn(t_turn), .t_setup(t_setup), .t_strobe(t_strobe), .t_hold(t_hold),
        .phase(phase), .cur_cs(cur_cs), .cur_addr(cur_addr),
        .strobe_last(strobe_last), .done_pulse(done_pulse), .abort_pulse(abort_pulse)
    );

    ars_pin_drv #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
                  .CS_W(CS_W), .BE_W(BE_W)) pins_i (
        .clk(clk), .rst(rst), .phase(phase), .cur_cs(cur_cs), .cur_addr(cur_addr),
        .cs_mode(t_mode), .strobe_last(strobe_last), .mem_din(mem_din),
        .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_be_n(mem_be_n), .mem_addr(mem_addr), .rd_data(rd_data), .rd_valid(rd_valid)
    );
endmodule

// File: rtl/async_rd_seq_chk.sv
module async_rd_seq_chk #(
    parameter int NUM_CS = 4,
    parameter int ADDR_W = 16,
    parameter int BE_W   = 2
) (
    input logic              clk,
    input logic              rst,
    input logic [NUM_CS-1:0] mem_cs_n,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic [BE_W-1:0]   mem_be_n,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              rd_valid,
    input logic              done_pulse,
    input logic              abort_pulse,
    input logic              req_ready
);
    AST_WE_STAYS_HIGH: assert property (@(posedge clk) disable iff (rst)
        mem_we_n == 1'b1); // R10
    AST_ONE_CS_AT_MOST: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~mem_cs_n)); // R12
    AST_OE_WITHIN_CS: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> (~mem_cs_n != '0)); // R6
    AST_ADDR_HELD_IN_STROBE: assert property (@(posedge clk) disable iff (rst)
        (!mem_oe_n && $past(!mem_oe_n)) |-> $stable(mem_addr)); // R6
    AST_RDV_FOLLOWS_STROBE: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(!mem_oe_n)); // R7
    AST_ABORT_NO_BUS: assert property (@(posedge clk) disable iff (rst)
        abort_pulse |-> ((&mem_cs_n) && (&$past(mem_cs_n)))); // R4
    AST_DONE_ABORT_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(done_pulse && abort_pulse)); // R9
    AST_DONE_READY: assert property (@(posedge clk) disable iff (rst)
        done_pulse |-> (req_ready && (&mem_cs_n))); // R9
    AST_BE_ONLY_IN_ACCESS: assert property (@(posedge clk) disable iff (rst)
        (mem_be_n != '1) |-> (~mem_cs_n != '0)); // R11
endmodule

bind async_rd_seq async_rd_seq_chk #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W), .BE_W(BE_W)) chk_i (
    .clk(clk), .rst(rst), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_be_n(mem_be_n), .mem_addr(mem_addr),
    .rd_valid(rd_valid), .done_pulse(done_pulse), .abort_pulse(abort_pulse),
    .req_ready(req_ready)
);

// File: tb/async_rd_seq_tb_top.sv
`timescale 1ns/1ps
module async_rd_seq_tb_top;
    localparam int NCS = 4;
    localparam int AW  = 16;
    localparam int DW  = 16;
    localparam int LW  = 3;
    localparam int CW  = 4;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            req_valid = 1'b0;
    logic [AW-1:0]   req_addr = '0;
    logic [LW-1:0]   req_len = '0;
    logic [1:0]      req_cs = '0;
    logic            req_grant = 1'b0;
    logic            req_ready;
    logic [NCS*CW-1:0] cfg_turn = '0, cfg_setup = '0, cfg_strobe = '0, cfg_hold = '0;
    logic [NCS-1:0]  cfg_mode = '0;
    logic [NCS-1:0]  mem_cs_n;
    logic            mem_oe_n, mem_we_n;
    logic [1:0]      mem_be_n;
    logic [AW-1:0]   mem_addr;
    logic [DW-1:0]   mem_din;
    logic [DW-1:0]   rd_data;
    logic            rd_valid, done_pulse, abort_pulse;

    int n_tests = 0;
    int n_fail  = 0;
    bit bl_valid = 1'b0;
    int bl_cs = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    function automatic logic [DW-1:0] mem_f(logic [AW-1:0] a);
        return (a * 16'h2F1B) ^ 16'hA55A;
    endfunction

    assign mem_din = mem_f(mem_addr);

    async_rd_seq #(.NUM_CS(NCS), .ADDR_W(AW), .DATA_W(DW), .LEN_W(LW), .CNT_W(CW)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_len(req_len), .req_cs(req_cs), .req_grant(req_grant), .req_ready(req_ready),
        .cfg_turn(cfg_turn), .cfg_setup(cfg_setup), .cfg_strobe(cfg_strobe),
        .cfg_hold(cfg_hold), .cfg_mode(cfg_mode), .mem_cs_n(mem_cs_n),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_be_n(mem_be_n),
        .mem_addr(mem_addr), .mem_din(mem_din), .rd_data(rd_data), .rd_valid(rd_valid),
        .done_pulse(done_pulse), .abort_pulse(abort_pulse)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
        end
    endtask

    // Target chip select gets the swept values, the others get distinct decoys.
    task automatic set_cfg(input int cs, input int ta, input int su, input int st,
                           input int ho, input bit md);
        for (int i = 0; i < NCS; i++) begin
            cfg_turn[i*CW +: CW]   = (i == cs) ? CW'(ta) : 4'd15;
            cfg_setup[i*CW +: CW]  = (i == cs) ? CW'(su) : 4'd14;
            cfg_strobe[i*CW +: CW] = (i == cs) ? CW'(st) : 4'd13;
            cfg_hold[i*CW +: CW]   = (i == cs) ? CW'(ho) : 4'd12;
            cfg_mode[i]            = (i == cs) ? md : ~md;
        end
    endtask

    // gm: 0 grant held high, 1 grant held low, 2 low at accept then high
    task automatic run_req(input int cs, input int base, input int len, input int ta,
                           input int su, input int st, input int ho, input bit md,
                           input int gm, input string ttag);
        int T, P, E, beats;
        bit ab;
        set_cfg(cs, ta, su, st, ho, md);
        T = (bl_valid && bl_cs == cs) ? 0 : ta;
        P = su + st + ho + 3;
        beats = len + 1;
        ab = (gm == 1) || (gm == 2 && T == 0);
        E = ab ? T : T + beats * P;
        req_valid = 1'b1; req_cs = 2'(cs); req_addr = AW'(base);
        req_len = LW'(len); req_grant = (gm == 0);
        chk(req_ready == 1'b1, "R9 ready before request", int'(req_ready), 1);
        @(posedge clk);
        for (int k = 0; k <= E + 1; k++) begin
            @(negedge clk);
            if (k == 0) begin
                req_valid = 1'b0;
                if (gm == 2) req_grant = 1'b1;
            end
            chk(mem_we_n == 1'b1, "R10 we_n", int'(mem_we_n), 1);
            if (ab) begin
                chk(mem_cs_n == 4'hF, "R4 no cs on abort", int'(mem_cs_n), 15);
                chk(abort_pulse == (k == T), "R4 abort pulse", int'(abort_pulse), int'(k == T));
                chk(done_pulse == 1'b0, "R4 no done on abort", int'(done_pulse), 0);
                chk(req_ready == (k >= T), "R4 ready after abort", int'(req_ready), int'(k >= T));
            end else begin
                bit in_acc;
                int off, bt;
                logic [3:0] ecs;
                logic [1:0] ebe;
                in_acc = (k >= T) && (k < E);
                off = in_acc ? (k - T) % P : 0;
                bt  = in_acc ? (k - T) / P : 0;
                ecs = in_acc ? ~(4'b0001 << cs) : 4'hF;
                ebe = (in_acc && !md) ? 2'b00 : 2'b11;
                if (k == T)
                    chk(mem_cs_n == ecs, {ttag, " first cs cycle"}, int'(mem_cs_n), int'(ecs));
                else
                    chk(mem_cs_n == ecs, in_acc ? "R12 cs select" : "R6 cs span",
                        int'(mem_cs_n), int'(ecs));
                chk(mem_oe_n == !(in_acc && off >= su + 1 && off < su + st + 2),
                    "R6 oe window", int'(mem_oe_n),
                    int'(!(in_acc && off >= su + 1 && off < su + st + 2)));
                chk(mem_be_n == ebe, "R11 byte enables", int'(mem_be_n), int'(ebe));
                chk(rd_valid == (in_acc && off == su + st + 2), "R7 rd_valid",
                    int'(rd_valid), int'(in_acc && off == su + st + 2));
                if (in_acc) begin
                    logic [AW-1:0] ea;
                    ea = AW'(base + bt);
                    chk(mem_addr == ea, "R8 address", int'(mem_addr), int'(ea));
                    if (off == su + st + 2)
                        chk(rd_data == mem_f(ea), "R7 rd_data", int'(rd_data), int'(mem_f(ea)));
                end
                chk(done_pulse == (k == E), "R9 done pulse", int'(done_pulse), int'(k == E));
                chk(abort_pulse == 1'b0, "R4 no abort", int'(abort_pulse), 0);
                chk(req_ready == (k >= E), "R9 ready", int'(req_ready), int'(k >= E));
            end
        end
        if (ab) bl_valid = 1'b0;
        else begin bl_valid = 1'b1; bl_cs = cs; end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        int it;
        int cs;
        it = 0;
        cs = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(mem_cs_n == 4'hF, "R1 cs after reset", int'(mem_cs_n), 15);
        chk(mem_oe_n == 1'b1, "R1 oe after reset", int'(mem_oe_n), 1);
        chk(mem_be_n == 2'b11, "R1 be after reset", int'(mem_be_n), 3);
        chk(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
        chk({rd_valid, done_pulse, abort_pulse} == 3'b000, "R1 pulses after reset",
            int'({rd_valid, done_pulse, abort_pulse}), 0);

        for (int ta = 0; ta <= 2; ta++)
            for (int su = 0; su <= 1; su++)
                for (int st = 0; st <= 2; st++)
                    for (int ho = 0; ho <= 1; ho++)
                        for (int ln = 0; ln <= 2; ln++) begin
                            cs = (cs + 1) % NCS;
                            run_req(cs, it * 7, ln, ta, su, st, ho, it[0], 0, "R2");
                            run_req(cs, it * 5 + 3, ln, ta, su, st, ho, ~it[0], 0, "R3");
                            it++;
                        end

        cs = (bl_cs + 1) % NCS;
        run_req(cs, 16'h0100, 1, 2, 1, 1, 0, 1'b0, 1, "R4");   // abort after turnaround
        run_req(cs, 16'h0200, 1, 2, 1, 1, 0, 1'b0, 0, "R5");   // history cleared
        run_req(cs, 16'h0300, 0, 2, 0, 0, 0, 1'b0, 1, "R4");   // abort, no turnaround
        run_req(cs, 16'h0400, 1, 3, 0, 1, 1, 1'b0, 2, "R4");   // grant rises in time
        cs = (cs + 2) % NCS;
        run_req(cs, 16'hFFFE, 7, 1, 0, 0, 0, 1'b0, 0, "R8");   // 8 beats, address wrap

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule